// File: doc/BRIEF.md
# Multi-source clock frequency meter

This block measures the frequency of one clock chosen from a bank of up to 128 on-chip clock inputs. A measurement opens a gate window whose length is a programmable number of reference ticks; one tick is `TICK_DIV` bus-clock cycles, which is one microsecond when the bus clock runs at `TICK_DIV` MHz. During the window the rising edges of the selected clock are counted in that clock's own domain. The final count is then handed back to the bus domain through a request/acknowledge style handshake, so with a one-microsecond tick the count equals the frequency in MHz times the gate length.

Software writes a single packed control word that holds the gate length, the source index and the control bits. It then polls the busy flag in the same word and reads the count from the result word. A continuous mode starts a new window after every result, and an optional one-cycle interrupt pulse marks the end of each window. Writing the control word while a window is in progress abandons that window and restarts with the new settings.

Top module: `fm_freq_meter`

## Requirements
- R1: After reset the control word reads 0 (busy, bit 31, clear), the result word reads 0 and `irq` is low.
- R2: The word is selected by `reg_addr[3:2]`. The control word at byte 0x4 holds gate length [15:0], enable [16], continuous [17], interrupt enable [18], run [19], source index [26:20] and read-only busy [31], with bits 30:27 reading 0. The result word at 0xC holds the count in [15:0], with [31:16] reading 0. The words at 0x0 and 0x8 read 0, and writes to them have no effect.
- R3: A measurement starts only from a control write with both enable (bit 16) and run (bit 19) set while idle. Busy rises after that write, and a write with only one of the two bits set leaves the block idle.
- R4: The window lasts gate × `TICK_DIV` bus cycles, with a gate of 0 treated as 1. Busy stays high at least that long, and the result is the number of rising edges of the selected clock within the window, within ±1.
- R5: The count saturates at 0xFFFF and does not wrap.
- R6: A source index that is at or above `NSRC`, or whose bit in `SRC_PRESENT` is 0, yields a count of 0.
- R7: The result word changes only when a window completes. It stays unchanged when enable is cleared afterwards and while the block is idle.
- R8: With continuous mode and enable set, a new window starts in the cycle a result is stored, so busy does not drop. Each window stores its own result.
- R9: With interrupt enable set, `irq` is high for exactly one cycle per completed window. With it clear, `irq` stays low.
- R10: A control write while busy abandons the window without a result update or interrupt, even in the cycle the window would have completed. A new window then starts with the new settings if enable and run are both set; otherwise the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; also the time base of the gate timer |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| meas_clk | input | NSRC | Clocks that can be measured, one per source index |
| reg_wr | input | 1 | Write strobe for the register word at `reg_addr` |
| reg_addr | input | 4 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the word at `reg_addr` (combinational) |
| irq | output | 1 | One-cycle pulse at each completed window when enabled |

## Verification
The sharpest coincidence is a control write that lands in the exact cycle a window completes: completion wants to store the result and pulse `irq`, while the write wants to abandon the window. The bench times a write that clears enable so that it reaches the same clock edge as the completion of a window on a tied-off source, whose completion cycle is exact. The write must win: no interrupt pulse is seen and busy falls without a result update. Other overlaps (result store with continuous re-arm, result store with interrupt) are judged by counting `irq` pulses and reading the result after each one.

// File: rtl/fm_pkg.sv
package fm_pkg;
   localparam int REG_AW  = 4;
   localparam int REG_DW  = 32;
   localparam int CNT_W   = 16;
   localparam int LEN_W   = 16;
   localparam int SRC_W   = 7;
   localparam int SRC_MAX = 1 << SRC_W;

   localparam logic [1:0] WI_DUTY   = 2'd0;
   localparam logic [1:0] WI_CTRL   = 2'd1;
   localparam logic [1:0] WI_AUX    = 2'd2;
   localparam logic [1:0] WI_RESULT = 2'd3;

   localparam int B_EN     = 16;
   localparam int B_CONT   = 17;
   localparam int B_IE     = 18;
   localparam int B_RUN    = 19;
   localparam int B_SRC_LO = 20;
   localparam int B_BUSY   = 31;

   typedef enum logic [1:0] {ST_IDLE, ST_GATE, ST_DRAIN} fm_state_e;
endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d};
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/fm_gate_timer.sv
module fm_gate_timer #(
   parameter int TICK_DIV = 100,
   parameter int LEN_W    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic [LEN_W-1:0] len,
   output logic             active,
   output logic             done
);
   localparam int PRE_W = $clog2(TICK_DIV);
   localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

   logic [PRE_W-1:0] pre_q;
   logic [LEN_W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         done   <= 1'b0;
         pre_q  <= '0;
         rem_q  <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            active <= 1'b1;
            pre_q  <= '0;
            rem_q  <= (len == '0) ? LEN_W'(1) : len;
         end else if (abort) begin
            active <= 1'b0;
         end else if (active) begin
            if (pre_q == PRE_LAST) begin
               pre_q <= '0;
               if (rem_q == LEN_W'(1)) begin
                  active <= 1'b0;
                  done   <= 1'b1;
               end else begin
                  rem_q <= rem_q - LEN_W'(1);
               end
            end else begin
               pre_q <= pre_q + PRE_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/fm_edge_counter.sv
module fm_edge_counter #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             mclk,
   input  logic             rst_n,
   input  logic             win,
   output logic [CNT_W-1:0] cnt,
   output logic             done
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic win_s;
   logic win_q;

   fm_sync #(.STAGES(SYNC_STAGES)) u_win_sync (
      .clk(mclk), .rst_n(rst_n), .d(win), .q(win_s)
   );

   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= 1'b0;
         cnt   <= '0;
         done  <= 1'b0;
      end else begin
         win_q <= win_s;
         if (win_s) begin
            done <= 1'b0;
            if (!win_q)              cnt <= CNT_W'(1);
            else if (cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
         end else if (win_q) begin
            done <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/fm_freq_meter.sv
module fm_freq_meter
   import fm_pkg::*;
#(
   parameter int              NSRC        = 128,
   parameter logic [NSRC-1:0] SRC_PRESENT = '1,
   parameter int              TICK_DIV    = 100,
   parameter int              SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   meas_clk,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   output logic              irq
);
   if (NSRC < 1 || NSRC > SRC_MAX) begin : g_bad_nsrc
      $error("fm_freq_meter: NSRC out of range");
   end
   if (TICK_DIV < 2) begin : g_bad_div
      $error("fm_freq_meter: TICK_DIV must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("fm_freq_meter: SYNC_STAGES must be at least 2");
   end

   // source bank: absent or out-of-range indices are tied low
   logic [SRC_MAX-1:0] gclk;
   logic [SRC_MAX-1:0] pres;
   for (genvar i = 0; i < SRC_MAX; i++) begin : g_src
      if (i < NSRC) begin : g_in
         if (SRC_PRESENT[i]) begin : g_on
            assign gclk[i] = meas_clk[i];
            assign pres[i] = 1'b1;
         end else begin : g_off
            assign gclk[i] = 1'b0;
            assign pres[i] = 1'b0;
         end
      end else begin : g_out
         assign gclk[i] = 1'b0;
         assign pres[i] = 1'b0;
      end
   end

   fm_state_e        state_q;
   logic [LEN_W-1:0] gate_q;
   logic             en_q, cont_q, ie_q, run_q;
   logic [SRC_W-1:0] src_q;
   logic [CNT_W-1:0] result_q;
   logic             irq_q, discard_q, armed_q;

   logic             ctrl_wr, w_en, w_run, busy, src_ok, sel_clk;
   logic             start_new, abort, drain_ok, fin, timer_start;
   logic [LEN_W-1:0] tmr_len;
   logic             tmr_active, tmr_done, win_out, done_m, done_b;
   logic [CNT_W-1:0] cnt_m;

   assign ctrl_wr = reg_wr && (reg_addr[3:2] == WI_CTRL);
   assign w_en    = reg_wdata[B_EN];
   assign w_run   = reg_wdata[B_RUN];
   assign busy    = (state_q != ST_IDLE);
   assign sel_clk = gclk[src_q];
   assign src_ok  = pres[src_q];

   always_comb begin
      start_new   = ctrl_wr && !busy && w_en && w_run;
      abort       = ctrl_wr && busy;
      drain_ok    = (state_q == ST_DRAIN) && (!src_ok || (armed_q && done_b));
      fin         = drain_ok && !ctrl_wr && !discard_q;
      timer_start = start_new ||
                    (drain_ok && !ctrl_wr &&
                     (discard_q ? (en_q && run_q) : (cont_q && en_q)));
      tmr_len     = start_new ? reg_wdata[LEN_W-1:0] : gate_q;
      // keep the window open until the measured side has seen it rise
      win_out     = tmr_active || (busy && !armed_q);
   end

   fm_gate_timer #(.TICK_DIV(TICK_DIV), .LEN_W(LEN_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .start(timer_start), .abort(abort),
      .len(tmr_len), .active(tmr_active), .done(tmr_done)
   );

   fm_edge_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_count (
      .mclk(sel_clk), .rst_n(rst_n), .win(win_out), .cnt(cnt_m), .done(done_m)
   );

   fm_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
      .clk(clk), .rst_n(rst_n), .d(done_m), .q(done_b)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         gate_q    <= '0;
         en_q      <= 1'b0;
         cont_q    <= 1'b0;
         ie_q      <= 1'b0;
         run_q     <= 1'b0;
         src_q     <= '0;
         result_q  <= '0;
         irq_q     <= 1'b0;
         discard_q <= 1'b0;
         armed_q   <= 1'b0;
      end else begin
         irq_q <= fin && ie_q;
         if (ctrl_wr) begin
            gate_q <= reg_wdata[LEN_W-1:0];
            en_q   <= w_en;
            cont_q <= reg_wdata[B_CONT];
            ie_q   <= reg_wdata[B_IE];
            run_q  <= w_run;
            src_q  <= reg_wdata[B_SRC_LO +: SRC_W];
         end
         if (fin) result_q <= src_ok ? cnt_m : '0;
         if (timer_start)          armed_q <= 1'b0;
         else if (busy && !done_b) armed_q <= 1'b1;

         if (start_new) begin
            state_q   <= ST_GATE;
            discard_q <= 1'b0;
         end else if (abort) begin
            state_q   <= ST_DRAIN;
            discard_q <= 1'b1;
         end else begin
            unique case (state_q)
               ST_GATE:  if (tmr_done) state_q <= ST_DRAIN;
               ST_DRAIN: if (drain_ok) begin
                  state_q   <= timer_start ? ST_GATE : ST_IDLE;
                  discard_q <= 1'b0;
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      unique case (reg_addr[3:2])
         WI_CTRL:   reg_rdata = {busy, 4'b0, src_q, run_q, ie_q, cont_q, en_q, gate_q};
         WI_RESULT: reg_rdata = {{(REG_DW-CNT_W){1'b0}}, result_q};
         default:   reg_rdata = '0;
      endcase
   end

   assign irq = irq_q;
endmodule

// File: rtl/fm_freq_meter_chk.sv
module fm_freq_meter_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr,
   input logic [3:0]  reg_addr,
   input logic [31:0] reg_wdata,
   input logic        irq,
   input logic        busy,
   input logic        fin,
   input logic        en_q,
   input logic        cont_q,
   input logic        ie_q,
   input logic [15:0] result_q
);
   // R9
   irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R9
   irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ie_q);

   // R3
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(reg_wr && reg_addr[3:2] == 2'd1 &&
                            reg_wdata[16] && reg_wdata[19]));

   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result_q) |-> $past(busy));

   // R10
   abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_wr && reg_addr[3:2] == 2'd1) |=> !irq);

   // R8
   cont_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && cont_q && en_q) |=> busy);
endmodule

bind fm_freq_meter fm_freq_meter_chk u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .irq(irq), .busy(busy), .fin(fin),
   .en_q(en_q), .cont_q(cont_q), .ie_q(ie_q), .result_q(result_q)
);

// File: tb/tb_fm_freq_meter.sv
`timescale 1ns/1ps
module tb_fm_freq_meter;
   localparam real CLK_PERIOD = 10.0;
   localparam int  NSRC = 4;
   localparam int  TDIV = 10;
   localparam logic [3:0] ADR_DUTY = 4'h0, ADR_CTRL = 4'h4, ADR_AUX = 4'h8, ADR_RES = 4'hC;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic [3:0]  mclk = 4'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = 4'h0;
   logic [31:0] reg_wdata = 32'h0;
   logic [31:0] reg_rdata;
   logic        irq;

   int errors = 0, checks = 0, irq_cnt = 0;
   bit irq_wide = 0, irq_prev = 0, finished = 0;
   // edges per tick of each source: 5 ns, 20 ns, 50 ns periods; index 3 tied off
   int rate[4] = '{20, 5, 2, 0};

   always #(CLK_PERIOD/2) clk = ~clk;
   always #2.5  mclk[0] = ~mclk[0];
   always #10.0 mclk[1] = ~mclk[1];
   always #25.0 mclk[2] = ~mclk[2];
   always #5.0  mclk[3] = ~mclk[3];

   fm_freq_meter #(.NSRC(NSRC), .SRC_PRESENT(4'b0111), .TICK_DIV(TDIV), .SYNC_STAGES(2)) dut (
      .clk(clk), .rst_n(rst_n), .meas_clk(mclk), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   always @(negedge clk) begin
      if (irq) begin
         irq_cnt++;
         if (irq_prev) irq_wide = 1;
      end
      irq_prev = irq;
   end

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_near(input string req, input longint act, input longint exp);
      chk((act >= exp - 1) && (act <= exp + 1), req, act, exp);
   endtask

   function automatic logic [31:0] word(int gate, bit en, bit cont, bit ie, bit run, int src);
      return (32'(src) << 20) | (32'(run) << 19) | (32'(ie) << 18) |
             (32'(cont) << 17) | (32'(en) << 16) | 32'(gate & 16'hFFFF);
   endfunction

   task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle(output int cyc);
      logic [31:0] d;
      cyc = 0;
      do begin
         reg_read(ADR_CTRL, d);
         cyc++;
      end while (d[31] && cyc < 60000);
   endtask

   task automatic measure(input int src, input int gate, input bit ie, output int res, output int cyc);
      logic [31:0] d;
      reg_write(ADR_CTRL, word(gate, 1, 0, ie, 1, src));
      wait_idle(cyc);
      reg_read(ADR_RES, d);
      res = int'(d);
   endtask

   task automatic wait_irq(input int target);
      int t = 0;
      while (irq_cnt < target && t < 2000) begin
         @(negedge clk); #1; t++;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, w;
      int res, cyc, base, last;
      int gates[4] = '{3, 5, 8, 20};

      repeat (3) @(negedge clk);
      // R1: reset state
      reg_read(ADR_CTRL, d);  chk(d == 0, "R1 ctrl", d, 0);
      reg_read(ADR_RES, d);   chk(d == 0, "R1 result", d, 0);
      chk(irq == 0, "R1 irq", irq, 0);
      rst_n = 1'b1;

      // R2: unused words and control field layout
      reg_write(ADR_DUTY, 32'hFFFF_FFFF);
      reg_write(ADR_AUX,  32'hFFFF_FFFF);
      reg_read(ADR_DUTY, d);  chk(d == 0, "R2 word 0x0", d, 0);
      reg_read(ADR_AUX, d);   chk(d == 0, "R2 word 0x8", d, 0);
      w = word(16'h1234, 1, 1, 1, 0, 5);
      reg_write(ADR_CTRL, w);
      reg_read(ADR_CTRL, d);  chk(d == w, "R2 ctrl readback", d, w);
      // R3: enable alone or run alone does not start
      chk(d[31] == 0, "R3 enable only", d[31], 0);
      reg_write(ADR_CTRL, word(5, 0, 0, 0, 1, 1));
      reg_read(ADR_CTRL, d);  chk(d[31] == 0, "R3 run only", d[31], 0);
      reg_write(ADR_CTRL, word(5, 1, 0, 0, 1, 1));
      reg_read(ADR_CTRL, d);  chk(d[31] == 1, "R3 both start", d[31], 1);
      wait_idle(cyc);

      // R4: sweep sources and gate lengths
      for (int s = 0; s < 3; s++) begin
         for (int g = 0; g < 4; g++) begin
            measure(s, gates[g], 0, res, cyc);
            chk_near($sformatf("R4 src%0d gate%0d", s, gates[g]), res, rate[s] * gates[g]);
         end
      end
      measure(1, 0, 0, res, cyc);
      chk_near("R4 gate zero", res, rate[1]);
      measure(1, 3, 0, res, cyc);
      chk(cyc >= 3*TDIV - 1 && cyc <= 3*TDIV + 40, "R4 busy length", cyc, 3*TDIV);
      reg_read(ADR_RES, d);
      chk(d[31:16] == 0, "R2 result upper", d[31:16], 0);

      // R6: tied-off and out-of-range indices
      measure(3, 5, 0, res, cyc);    chk(res == 0, "R6 absent source", res, 0);
      measure(5, 5, 0, res, cyc);    chk(res == 0, "R6 index above NSRC", res, 0);
      measure(127, 5, 0, res, cyc);  chk(res == 0, "R6 index 127", res, 0);

      // R5: saturation
      measure(0, 3500, 0, res, cyc);
      chk(res == 16'hFFFF, "R5 saturate", res, 16'hFFFF);

      // R9: interrupt pulses
      base = irq_cnt;
      measure(2, 5, 1, res, cyc);
      chk(irq_cnt - base == 1, "R9 one pulse", irq_cnt - base, 1);
      chk(irq_wide == 0, "R9 single cycle", irq_wide, 0);
      base = irq_cnt;
      measure(2, 5, 0, res, cyc);
      chk(irq_cnt == base, "R9 disabled", irq_cnt - base, 0);

      // R7: stable after enable cleared and while idle
      measure(1, 7, 0, res, cyc);
      last = res;
      reg_write(ADR_CTRL, word(7, 0, 0, 0, 0, 1));
      reg_read(ADR_RES, d);   chk(d == last, "R7 after enable clear", d, last);
      repeat (50) @(negedge clk);
      reg_read(ADR_RES, d);   chk(d == last, "R7 idle hold", d, last);

      // R8: continuous mode
      base = irq_cnt;
      reg_write(ADR_CTRL, word(4, 1, 1, 1, 1, 1));
      for (int k = 1; k <= 3; k++) begin
         wait_irq(base + k);
         reg_read(ADR_RES, d);
         chk_near($sformatf("R8 window %0d", k), d, 4 * rate[1]);
      end
      reg_read(ADR_CTRL, d);  chk(d[31] == 1, "R8 busy held", d[31], 1);
      last = int'(d);
      reg_read(ADR_RES, d);
      last = int'(d);
      base = irq_cnt;
      // R10: clearing enable while busy returns to idle without a result
      reg_write(ADR_CTRL, word(4, 0, 1, 1, 0, 1));
      wait_idle(cyc);
      reg_read(ADR_RES, d);
      chk(d == last, "R10 abort to idle keeps result", d, last);
      chk(irq_cnt == base, "R10 abort to idle no irq", irq_cnt - base, 0);

      // R10: abort and restart with new settings
      base = irq_cnt;
      reg_write(ADR_CTRL, word(50, 1, 0, 1, 1, 0));
      repeat (100) @(negedge clk);
      reg_write(ADR_CTRL, word(3, 1, 0, 1, 1, 1));
      wait_idle(cyc);
      reg_read(ADR_RES, d);
      chk_near("R10 restart count", d, 3 * rate[1]);
      chk(irq_cnt - base == 1, "R10 restart irq", irq_cnt - base, 1);

      // R10: write in the completion cycle of a tied-off window wins
      base = irq_cnt;
      reg_write(ADR_CTRL, word(2, 1, 0, 1, 1, 3));
      repeat (2*TDIV) @(negedge clk);
      reg_write(ADR_CTRL, word(2, 0, 0, 1, 0, 3));
      repeat (5) @(negedge clk);
      chk(irq_cnt == base, "R10 same-cycle write no irq", irq_cnt - base, 0);
      reg_read(ADR_CTRL, d);  chk(d[31] == 0, "R10 same-cycle idle", d[31], 0);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule